// File: doc/BRIEF.md
# MMU Fault Recorder with Pseudo-Random Refill Way

This block sits beside a TLB lookup and records what went wrong whenever a translation fails. On each fault strobe it captures the faulting virtual page, the current 8-bit process ID and the access type into a cause register. It also loads a select register with the TLB index and the way that software should use when it services the fault. The TLB lookup, the protection checks and the address formation are done elsewhere. This block only receives their outcome: whether the fault was a miss, and which way hit when the fault was a protection denial.

The refill way for a miss comes from a 16-bit Galois-free shift register (a Fibonacci LFSR). The LFSR advances once per fault and never on a good translation. Software reads and writes both registers through a small register port, so a fault handler can inspect the cause and then program the selected TLB slot.

Top module: `fault_rec`

## Requirements
- R1: After reset the LFSR holds 0xCCCC, and the select and cause registers read 0.
- R2: On every fault, whether a miss or a protection denial, the LFSR takes a new state. The new feedback bit is the parity of (old state AND 0x8805). The state shifts right by one and the feedback bit enters at bit 15.
- R3: In any cycle without a fault strobe the LFSR keeps its value.
- R4: On a miss (`flt_miss`=1) the recorded way is bits 1:0 of the LFSR as it was before that fault's update.
- R5: On a protection fault (`flt_miss`=0) the recorded way is `flt_hit_way`.
- R6: On a fault the select register becomes zero except for bits 3:0, which take the low 4 bits of the virtual page number (the TLB index), and bits 5:4, which take the recorded way.
- R7: On a fault the cause register takes the PID in bits 7:0, the access type in bits 9:8 and the virtual page number in bits 31:13. Bits 12:10 keep their previous value.
- R8: The access type is stored as given, with 0 for read, 1 for write and 2 for execute.
- R9: With `reg_addr`=0, `reg_rdata` shows the select register; with `reg_addr`=1 it shows the cause register. A write with `reg_wr`=1 replaces the addressed register at the next clock edge, and the LFSR is not affected by it.
- R10: When a fault and a software write occur in the same cycle, the fault update is what both registers hold afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| flt_valid | input | 1 | Fault strobe, one cycle per fault |
| flt_miss | input | 1 | 1 = TLB miss, 0 = protection denial after a hit |
| flt_vpn | input | 19 | Faulting virtual page number |
| flt_pid | input | 8 | Current process ID |
| flt_acc | input | 2 | Access type: 0 read, 1 write, 2 execute |
| flt_hit_way | input | 2 | Way that matched (used on protection faults) |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 = select register, 1 = cause register |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the addressed register |
| refill_way | output | 2 | Way the next miss would use |
| rng_state | output | 16 | Current LFSR state |

## Verification
The hardest case to reach from the ports is the preservation of cause bits 12:10. A fault never writes those bits, so they can only become non-zero through a software write, and the proof that a fault keeps them needs a fault that follows such a write. The sweep therefore writes random data to the cause register just before some faults, and it also lines software writes up in the same cycle as faults. Long runs of faults interleaved with idle cycles carry the LFSR through hundreds of states, so that both way sources and all three access types are recorded against a bench-side model of the register.

// File: rtl/fault_rec.sv
module fault_rec #(
  parameter logic [15:0] SEED  = 16'hCCCC,
  parameter logic [15:0] TAPS  = 16'h8805,
  parameter int          VPN_W = 19,
  parameter int          IDX_W = 4,
  parameter int          WAY_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flt_valid,
  input  logic             flt_miss,
  input  logic [VPN_W-1:0] flt_vpn,
  input  logic [7:0]       flt_pid,
  input  logic [1:0]       flt_acc,
  input  logic [WAY_W-1:0] flt_hit_way,
  input  logic             reg_wr,
  input  logic             reg_addr,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  output logic [WAY_W-1:0] refill_way,
  output logic [15:0]      rng_state
);
  localparam int DW      = 32;
  localparam int VPN_LSB = DW - VPN_W;

  logic [15:0]    rng_q;
  logic [DW-1:0]  sel_q, cause_q, sel_new, cause_new;
  logic [WAY_W-1:0] way;

  wire fb = ^(rng_q & TAPS);
  wire [15:0] rng_nxt = {fb, rng_q[15:1]};

  assign way = flt_miss ? rng_q[WAY_W-1:0] : flt_hit_way;

  always_comb begin
    sel_new = '0;
    sel_new[IDX_W-1:0] = flt_vpn[IDX_W-1:0];
    sel_new[IDX_W +: WAY_W] = way;
    cause_new = cause_q;
    cause_new[7:0] = flt_pid;
    cause_new[9:8] = flt_acc;
    cause_new[DW-1:VPN_LSB] = flt_vpn;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rng_q   <= SEED;
      sel_q   <= '0;
      cause_q <= '0;
    end else if (flt_valid) begin
      rng_q   <= rng_nxt;
      sel_q   <= sel_new;
      cause_q <= cause_new;
    end else if (reg_wr) begin
      if (reg_addr) cause_q <= reg_wdata;
      else          sel_q   <= reg_wdata;
    end
  end

  assign reg_rdata  = reg_addr ? cause_q : sel_q;
  assign refill_way = rng_q[WAY_W-1:0];
  assign rng_state  = rng_q;
endmodule

module fault_rec_chk #(
  parameter int VPN_W = 19,
  parameter int WAY_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             flt_valid,
  input logic             flt_miss,
  input logic [VPN_W-1:0] flt_vpn,
  input logic [WAY_W-1:0] flt_hit_way,
  input logic [15:0]      rng_q,
  input logic [31:0]      sel_q,
  input logic [31:0]      cause_q
);
  a_r3_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !flt_valid |=> $stable(rng_q));
  a_r2_moves_on_fault: assert property (@(posedge clk) disable iff (!rst_n)
    flt_valid |=> rng_q[14:0] == $past(rng_q[15:1]));
  a_r4_miss_way: assert property (@(posedge clk) disable iff (!rst_n)
    flt_valid && flt_miss |=> sel_q[5:4] == $past(rng_q[1:0]));
  a_r5_hit_way: assert property (@(posedge clk) disable iff (!rst_n)
    flt_valid && !flt_miss |=> sel_q[5:4] == $past(flt_hit_way));
  a_r6_sel_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    flt_valid |=> sel_q[31:6] == '0);
  a_r7_keep_mid: assert property (@(posedge clk) disable iff (!rst_n)
    flt_valid |=> cause_q[12:10] == $past(cause_q[12:10]));
  a_r10_fault_wins: assert property (@(posedge clk) disable iff (!rst_n)
    flt_valid |=> cause_q[31:13] == $past(flt_vpn));
endmodule

bind fault_rec fault_rec_chk #(.VPN_W(VPN_W), .WAY_W(WAY_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .flt_valid(flt_valid), .flt_miss(flt_miss),
  .flt_vpn(flt_vpn), .flt_hit_way(flt_hit_way), .rng_q(rng_q),
  .sel_q(sel_q), .cause_q(cause_q)
);

// File: tb/test_fault_rec.sv
`timescale 1ns/1ps
module test_fault_rec;
  logic clk = 0, rst_n = 0;
  logic flt_valid = 0, flt_miss = 0, reg_wr = 0, reg_addr = 0;
  logic [18:0] flt_vpn = '0;
  logic [7:0]  flt_pid = '0;
  logic [1:0]  flt_acc = '0, flt_hit_way = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic [1:0]  refill_way;
  logic [15:0] rng_state;

  int checks = 0, errors = 0;
  logic [15:0] m_rng;
  logic [31:0] m_sel, m_cause;

  always #2.5 clk = ~clk;

  fault_rec i_fault_rec (.*);

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  function automatic logic [15:0] step_rng(logic [15:0] s);
    int p = 0;
    for (int b = 0; b < 16; b++) p += (s[b] & ((16'h8805 >> b) & 1));
    return {p[0], s[15:1]};
  endfunction

  task automatic compare_all(string tag);
    reg_addr = 0; #0.5;
    check({tag, " sel"}, reg_rdata, m_sel);
    reg_addr = 1; #0.5;
    check({tag, " cause"}, reg_rdata, m_cause);
    check({tag, " rng"}, {16'h0, rng_state}, {16'h0, m_rng});
    check({tag, " refill"}, {30'h0, refill_way}, {30'h0, m_rng[1:0]});
  endtask

  task automatic cycle(bit v, bit miss, logic [18:0] vpn, logic [7:0] pid,
                       logic [1:0] acc, logic [1:0] hw, bit wr, bit a,
                       logic [31:0] wd);
    @(negedge clk);
    flt_valid = v; flt_miss = miss; flt_vpn = vpn; flt_pid = pid;
    flt_acc = acc; flt_hit_way = hw; reg_wr = wr; reg_addr = a; reg_wdata = wd;
    if (v) begin
      m_sel = {26'h0, (miss ? m_rng[1:0] : hw), vpn[3:0]};
      m_cause = {vpn, m_cause[12:10], acc, pid};
      m_rng = step_rng(m_rng);
    end else if (wr) begin
      if (a) m_cause = wd; else m_sel = wd;
    end
    @(posedge clk); #1;
    flt_valid = 0; reg_wr = 0;
  endtask

  initial begin
    #200000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    m_rng = 16'hCCCC; m_sel = 0; m_cause = 0;
    #12 rst_n = 1; #1;
    compare_all("R1 reset");

    // R2 R4 R5 R6 R7 R8 sweep; R3 idle cycles; R9 writes before faults
    for (int i = 0; i < 400; i++) begin
      logic [18:0] vpn = 19'(i * 7919 + 3);
      if (i % 7 == 2)
        cycle(0, 0, 0, 0, 0, 0, 1, 1, 32'h1C00 ^ (32'(i) * 32'h9E3779B1));
      if (i % 5 == 4) begin
        cycle(0, 1, vpn, 8'hAA, 2'd1, 2'd3, 0, 0, 0);
        compare_all("R3 idle");
      end
      cycle(1, (i % 4) != 3, vpn, 8'(i * 37), 2'(i % 3), 2'(i / 3), 0, 0, 0);
      compare_all((i % 4) != 3 ? "R2 R4 R6 R7 R8 miss" : "R2 R5 R6 R7 R8 prot");
    end

    // R9 write/read of both registers, LFSR untouched
    cycle(0, 0, 0, 0, 0, 0, 1, 0, 32'hDEADBEEF);
    compare_all("R9 sel write");
    cycle(0, 0, 0, 0, 0, 0, 1, 1, 32'h0BADF00D);
    compare_all("R9 cause write");

    // R7 bits 12:10 survive a fault after a software write
    cycle(0, 0, 0, 0, 0, 0, 1, 1, 32'h0000_1C00);
    cycle(1, 1, 19'h7FFFF, 8'h5A, 2'd2, 0, 0, 0, 0);
    compare_all("R7 keep 12:10");

    // R10 same-cycle write loses to fault, both addresses
    cycle(1, 0, 19'h12345, 8'h77, 2'd0, 2'd2, 1, 1, 32'hFFFFFFFF);
    compare_all("R10 cause conflict");
    cycle(1, 1, 19'h0ABCD, 8'h01, 2'd1, 2'd0, 1, 0, 32'hFFFFFFFF);
    compare_all("R10 sel conflict");

    // R1 reset again mid-run
    @(negedge clk); rst_n = 0; #3; rst_n = 1;
    m_rng = 16'hCCCC; m_sel = 0; m_cause = 0; #1;
    compare_all("R1 re-reset");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule